// File: doc/BRIEF.md
# Dual-Counter Alarm Timer

This block is a system time base built from two free-running counters and a bank of alarm comparators. Both counters move only on a tick-enable input, which stands for a fixed 16 MHz time base derived elsewhere on the chip. The tick-enable keeps every counter and comparator in the one fast clock domain. Each counter has a run control, and it can also be told to freeze while an external halt input is high. That input is meant for a stalled CPU or a core held by a debugger.

Each comparator watches one of the two counters, and a control bit picks which one. A comparator works in one of two modes. In target mode it raises its interrupt once, when the chosen counter arrives at a full-width target, and then disarms itself. In period mode it raises its interrupt each time the counter arrives at the target, and then moves the target forward by a narrower period value. Every interrupt is a sticky level with its own write-one-to-clear input.

A host write port loads counter values, sets targets, periods and modes, and copies either counter into a snapshot register. Software reads the whole counter value from that register in one coherent piece.

Top module: `tbase_timer`

## Requirements
- R1: After synchronous reset both counters hold zero and are stopped, with the run bit and the halt-sensitive bit clear. Every comparator is disabled, all interrupt outputs are low and `snap_val` is zero.
- R2: The control word of counter c is at address 2+c: bit 0 is run and bit 1 is halt-sensitive. A running counter goes up by exactly one on each clock cycle in which `tick` is high. No counter changes in a cycle without `tick`.
- R3: A counter whose halt-sensitive bit is set holds its value through ticks while `halt_in` is high. A counter whose halt-sensitive bit is clear keeps counting whatever `halt_in` does.
- R4: A write to address 0+c stages a new value for counter c. The counter keeps its old value until the next tick, and on that tick it takes the staged value. This holds even when the counter is stopped or halted.
- R5: A write to address 4 copies counter `host_wdata[0]` into `snap_val`, all bits in the same cycle. `snap_val` then stays unchanged until the next such write.
- R6: The configuration of comparator k is at address 5+k: bit 0 is enable, bit 1 is mode (0 for target, 1 for period) and bit 2 selects the counter. Its target is at address 8+k. An enabled comparator in target mode sets its interrupt when its counter takes a value equal to the target on a tick, by counting or by a load. The interrupt is visible one cycle after the counter update. After this one hit the comparator disables itself and fires no more.
- R7: A target that is already behind the counter when the comparator is armed raises no interrupt until the counter wraps from all ones to zero and counts up to it.
- R8: The period of comparator k is at address 12+k, and its low PER_W bits are used. In period mode every hit adds the period to the target, modulo 2^CNT_W, so alarms repeat every period ticks, across the counter wrap as well.
- R9: A comparator reacts only to the counter its select bit names.
- R10: An interrupt stays high until a one is applied on its bit of `irq_clr`. A hit in the same cycle as a clear leaves the interrupt set.
- R11: A disabled comparator never sets its interrupt, even when its counter passes through the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base enable, one cycle per count step |
| halt_in | input | 1 | CPU-stall or debug-halt request |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 4 | Host write address |
| host_wdata | input | CNT_W | Host write data |
| irq_clr | input | N_CMP | Write-one-to-clear, one bit per interrupt |
| snap_val | output | CNT_W | Coherent counter snapshot |
| irq | output | N_CMP | Sticky interrupt level per comparator |

## Verification
The bench builds the block with 12-bit counters and a 6-bit period, with three comparators. At that width a wrap takes only 4096 ticks. The bench can therefore count a counter all the way round to reach a target that was left behind, prove that a disarmed one-shot stays silent for a full revolution, and watch a periodic target roll over zero. The bench also times a clear pulse to land on the same edge as a hit, so the set-over-clear priority is exercised directly.

// File: rtl/tbt_pkg.sv
package tbt_pkg;

    localparam int ADDR_W   = 4;
    localparam int N_COUNTS = 2;

    // Host address map: per-instance registers sit at base + index.
    localparam logic [ADDR_W-1:0] A_LOAD0 = 4'h0;
    localparam logic [ADDR_W-1:0] A_CCTL0 = 4'h2;
    localparam logic [ADDR_W-1:0] A_SNAP  = 4'h4;
    localparam logic [ADDR_W-1:0] A_ACFG0 = 4'h5;
    localparam logic [ADDR_W-1:0] A_TGT0  = 4'h8;
    localparam logic [ADDR_W-1:0] A_PER0  = 4'hC;

    typedef enum logic {
        MODE_TARGET = 1'b0,
        MODE_PERIOD = 1'b1
    } alarm_mode_e;

    // Bit 2: counter select, bit 1: mode, bit 0: enable.
    typedef struct packed {
        logic        sel;
        alarm_mode_e mode;
        logic        en;
    } alarm_cfg_t;

    // Bit 1: halt-sensitive, bit 0: run.
    typedef struct packed {
        logic halt_sens;
        logic run;
    } cnt_ctl_t;

    function automatic logic reg_hit(logic [ADDR_W-1:0] addr,
                                     logic [ADDR_W-1:0] base, int idx);
        return addr == (base + ADDR_W'(idx));
    endfunction

endpackage

// File: rtl/tbt_counter.sv
module tbt_counter
    import tbt_pkg::*;
#(
    parameter int CNT_W = 52
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt_in,
    input  logic             ctl_we,
    input  cnt_ctl_t         ctl_in,
    input  logic             load_we,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_o,
    output logic             upd_o
);

    cnt_ctl_t         ctl_q;
    logic             pend_q;
    logic [CNT_W-1:0] ld_q;
    logic [CNT_W-1:0] cnt_q;
    logic             upd_q;
    logic             advance;

    assign advance = ctl_q.run && !(ctl_q.halt_sens && halt_in);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            pend_q <= 1'b0;
            ld_q   <= '0;
            cnt_q  <= '0;
            upd_q  <= 1'b0;
        end else begin
            upd_q <= 1'b0;
            if (ctl_we) ctl_q <= ctl_in;
            if (tick && pend_q) begin
                cnt_q <= ld_q;
                upd_q <= 1'b1;
            end else if (tick && advance) begin
                cnt_q <= cnt_q + 1'b1;
                upd_q <= 1'b1;
            end
            if (load_we) begin
                ld_q   <= load_val;
                pend_q <= 1'b1;
            end else if (tick) begin
                pend_q <= 1'b0;
            end
        end
    end

    assign cnt_o = cnt_q;
    assign upd_o = upd_q;

    // R2: no movement without a tick
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));

    // R2: a running, unblocked counter steps by one
    a_r2_single_step: assert property (@(posedge clk) disable iff (rst)
        tick && !pend_q && advance |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    // R3: halted counter holds through a tick
    a_r3_halt_hold: assert property (@(posedge clk) disable iff (rst)
        tick && !pend_q && ctl_q.halt_sens && halt_in |=> $stable(cnt_q));

    // R4: staged value lands on the tick
    a_r4_load_apply: assert property (@(posedge clk) disable iff (rst)
        tick && pend_q |=> cnt_q == $past(ld_q));

endmodule

// File: rtl/tbt_alarm.sv
module tbt_alarm
    import tbt_pkg::*;
#(
    parameter int CNT_W = 52,
    parameter int PER_W = 26
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  alarm_cfg_t       cfg_in,
    input  logic             tgt_we,
    input  logic [CNT_W-1:0] tgt_in,
    input  logic             per_we,
    input  logic [PER_W-1:0] per_in,
    input  logic [CNT_W-1:0] cnt_a,
    input  logic [CNT_W-1:0] cnt_b,
    input  logic [1:0]       upd,
    input  logic             irq_clr,
    output logic             irq_o
);

    alarm_cfg_t       cfg_q;
    logic [CNT_W-1:0] tgt_q;
    logic [PER_W-1:0] per_q;
    logic             irq_q;
    logic [CNT_W-1:0] cnt_sel;
    logic             hit;

    assign cnt_sel = cfg_q.sel ? cnt_b : cnt_a;
    assign hit     = cfg_q.en && upd[cfg_q.sel] && (cnt_sel == tgt_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            tgt_q <= '0;
            per_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (cfg_we)
                cfg_q <= cfg_in;
            else if (hit && cfg_q.mode == MODE_TARGET)
                cfg_q.en <= 1'b0;
            if (tgt_we)
                tgt_q <= tgt_in;
            else if (hit && cfg_q.mode == MODE_PERIOD)
                tgt_q <= tgt_q + CNT_W'(per_q);
            if (per_we) per_q <= per_in;
            irq_q <= hit | (irq_q & ~irq_clr);
        end
    end

    assign irq_o = irq_q;

    // R10: level stays up until cleared
    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        irq_q && !irq_clr |=> irq_q);

    // R10: a hit beats a concurrent clear
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
        hit |=> irq_q);

    // R11: disabled comparator stays quiet
    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !cfg_q.en && !irq_q |=> !irq_q);

    // R6: one-shot disarms after its hit
    a_r6_disarm: assert property (@(posedge clk) disable iff (rst)
        hit && cfg_q.mode == MODE_TARGET && !cfg_we |=> !cfg_q.en);

    // R8: periodic target advances by the period
    a_r8_period_step: assert property (@(posedge clk) disable iff (rst)
        hit && cfg_q.mode == MODE_PERIOD && !tgt_we
        |=> tgt_q == $past(tgt_q) + CNT_W'($past(per_q)));

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
    import tbt_pkg::*;
#(
    parameter int CNT_W = 52,
    parameter int PER_W = 26,
    parameter int N_CMP = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              halt_in,
    input  logic              host_we,
    input  logic [3:0]        host_addr,
    input  logic [CNT_W-1:0]  host_wdata,
    input  logic [N_CMP-1:0]  irq_clr,
    output logic [CNT_W-1:0]  snap_val,
    output logic [N_CMP-1:0]  irq
);

    logic [CNT_W-1:0] cnt_v [N_COUNTS];
    logic [1:0]       upd_v;
    logic [CNT_W-1:0] snap_q;
    logic             snap_we;

    generate
        for (genvar c = 0; c < N_COUNTS; c++) begin : g_cnt
            tbt_counter #(.CNT_W(CNT_W)) u_cnt (
                .clk     (clk),
                .rst     (rst),
                .tick    (tick),
                .halt_in (halt_in),
                .ctl_we  (host_we && reg_hit(host_addr, A_CCTL0, c)),
                .ctl_in  (cnt_ctl_t'(host_wdata[1:0])),
                .load_we (host_we && reg_hit(host_addr, A_LOAD0, c)),
                .load_val(host_wdata),
                .cnt_o   (cnt_v[c]),
                .upd_o   (upd_v[c])
            );
        end

        for (genvar k = 0; k < N_CMP; k++) begin : g_alm
            tbt_alarm #(.CNT_W(CNT_W), .PER_W(PER_W)) u_alm (
                .clk    (clk),
                .rst    (rst),
                .cfg_we (host_we && reg_hit(host_addr, A_ACFG0, k)),
                .cfg_in (alarm_cfg_t'(host_wdata[2:0])),
                .tgt_we (host_we && reg_hit(host_addr, A_TGT0, k)),
                .tgt_in (host_wdata),
                .per_we (host_we && reg_hit(host_addr, A_PER0, k)),
                .per_in (host_wdata[PER_W-1:0]),
                .cnt_a  (cnt_v[0]),
                .cnt_b  (cnt_v[1]),
                .upd    (upd_v),
                .irq_clr(irq_clr[k]),
                .irq_o  (irq[k])
            );
        end
    endgenerate

    assign snap_we = host_we && (host_addr == A_SNAP);

    always_ff @(posedge clk) begin
        if (rst)
            snap_q <= '0;
        else if (snap_we)
            snap_q <= cnt_v[host_wdata[0]];
    end

    assign snap_val = snap_q;

    // R5: snapshot only moves on a snapshot write
    a_r5_snap_stable: assert property (@(posedge clk) disable iff (rst)
        !snap_we |=> $stable(snap_q));

endmodule

// File: tb/tbase_timer_tb.sv
`timescale 1ns/1ps
module tbase_timer_tb;

    localparam int CNT_W = 12;
    localparam int PER_W = 6;
    localparam int N_CMP = 3;

    logic             clk = 1'b0;
    logic             rst;
    logic             tick;
    logic             halt_in;
    logic             host_we;
    logic [3:0]       host_addr;
    logic [CNT_W-1:0] host_wdata;
    logic [N_CMP-1:0] irq_clr;
    logic [CNT_W-1:0] snap_val;
    logic [N_CMP-1:0] irq;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [CNT_W-1:0] m_cnt [2];
    logic [CNT_W-1:0] m_ld  [2];
    bit               m_pend[2];
    bit               m_run [2];
    bit               m_hs  [2];

    always #2.5 clk = ~clk;

    tbase_timer #(.CNT_W(CNT_W), .PER_W(PER_W), .N_CMP(N_CMP)) u_dut (
        .clk(clk), .rst(rst), .tick(tick), .halt_in(halt_in),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .irq_clr(irq_clr), .snap_val(snap_val), .irq(irq)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<=150000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [CNT_W-1:0] d);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        if (a < 4'd2) begin
            m_ld[a[0]] = d; m_pend[a[0]] = 1'b1;
        end else if (a == 4'd2 || a == 4'd3) begin
            m_run[a[0]] = d[0]; m_hs[a[0]] = d[1];
        end
    endtask

    task automatic model_tick();
        for (int c = 0; c < 2; c++) begin
            if (m_pend[c]) begin
                m_cnt[c] = m_ld[c]; m_pend[c] = 1'b0;
            end else if (m_run[c] && !(m_hs[c] && halt_in)) begin
                m_cnt[c] = m_cnt[c] + 1'b1;
            end
        end
    endtask

    task automatic tick_n(int n);
        repeat (n) begin
            tick = 1'b1; model_tick();
            @(negedge clk);
            tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // one tick with a clear pulse on the edge where the hit is recorded
    task automatic tick_clr(int k);
        tick = 1'b1; model_tick();
        @(negedge clk);
        tick = 1'b0; irq_clr[k] = 1'b1;
        @(negedge clk);
        irq_clr = '0;
    endtask

    task automatic clr(int k);
        irq_clr[k] = 1'b1;
        @(negedge clk);
        irq_clr = '0;
    endtask

    task automatic snap_chk(string req, int c, logic [CNT_W-1:0] exp);
        wr(4'd4, CNT_W'(c));
        chk(req, 64'(snap_val), 64'(exp));
    endtask

    task automatic t_reset();
        chk("R1 irq", 64'(irq), 64'd0);
        chk("R1 snap", 64'(snap_val), 64'd0);
        snap_chk("R1 counter1", 1, '0);
        tick_n(2);
        snap_chk("R1 stopped", 0, '0);
    endtask

    task automatic t_count();
        wr(4'd2, 12'd1);
        tick_n(5);
        snap_chk("R2 five ticks", 0, 12'd5);
        cyc(10);
        snap_chk("R2 no tick hold", 0, 12'd5);
        chk("R5 snap held", 64'(snap_val), 64'd5);
    endtask

    task automatic t_stall();
        wr(4'd2, 12'd3);
        wr(4'd3, 12'd1);
        halt_in = 1'b1;
        tick_n(3);
        snap_chk("R3 halted holds", 0, 12'd5);
        snap_chk("R3 insensitive counts", 1, 12'd3);
        halt_in = 1'b0;
        tick_n(2);
        snap_chk("R3 resume", 0, 12'd7);
    endtask

    task automatic t_load();
        wr(4'd0, 12'h100);
        snap_chk("R4 before tick", 0, m_cnt[0]);
        tick_n(1);
        snap_chk("R4 applied", 0, 12'h100);
        wr(4'd3, 12'd0);
        wr(4'd1, 12'h0AB);
        tick_n(1);
        snap_chk("R4 stopped load", 1, 12'h0AB);
        tick_n(1);
        snap_chk("R4 stays stopped", 1, 12'h0AB);
        wr(4'd3, 12'd1);
    endtask

    task automatic t_target();
        wr(4'd8, m_cnt[0] + 12'd4);
        wr(4'd5, 12'd1);
        tick_n(3);
        chk("R6 before target", 64'(irq), 64'd0);
        tick_n(1);
        chk("R6 target hit", 64'(irq), 64'b001);
        clr(0);
        chk("R10 cleared", 64'(irq), 64'd0);
    endtask

    task automatic t_sticky();
        wr(4'd9, m_cnt[1] + 12'd2);
        wr(4'd6, 12'd5);
        tick_n(2);
        chk("R9 counter1 hit", 64'(irq), 64'b010);
        cyc(5);
        chk("R10 sticky", 64'(irq), 64'b010);
        clr(1);
        chk("R10 w1c", 64'(irq), 64'd0);
        wr(4'd9, m_cnt[1] + 12'd2);
        wr(4'd6, 12'd5);
        tick_n(1);
        tick_clr(1);
        chk("R10 set wins", 64'(irq), 64'b010);
        clr(1);
    endtask

    task automatic t_select();
        logic [CNT_W-1:0] t;
        t = m_cnt[0] + 12'd2;
        wr(4'd10, t);
        wr(4'd7, 12'd5);
        tick_n(2);
        snap_chk("R9 counter0 at target", 0, t);
        chk("R9 other counter ignored", 64'(irq), 64'd0);
        wr(4'd7, 12'd0);
    endtask

    task automatic t_disabled();
        wr(4'd10, m_cnt[1] + 12'd1);
        wr(4'd7, 12'd4);
        tick_n(1);
        chk("R11 disabled", 64'(irq), 64'd0);
    endtask

    task automatic t_period();
        wr(4'd10, m_cnt[1] + 12'd2);
        wr(4'd14, 12'd3);
        wr(4'd7, 12'd7);
        tick_n(2);
        chk("R8 first", 64'(irq), 64'b100);
        clr(2);
        tick_n(2);
        chk("R8 between", 64'(irq), 64'd0);
        tick_n(1);
        chk("R8 second", 64'(irq), 64'b100);
        clr(2);
        tick_n(3);
        chk("R8 third", 64'(irq), 64'b100);
        clr(2);
        wr(4'd7, 12'd0);
    endtask

    task automatic t_wrap();
        wr(4'd0, 12'hFF0);
        tick_n(1);
        wr(4'd8, 12'hFE0);
        wr(4'd5, 12'd1);
        wr(4'd9, 12'hFFE);
        wr(4'd13, 12'd4);
        wr(4'd6, 12'd3);
        tick_n(14);
        chk("R8 pre-wrap hit", 64'(irq), 64'b010);
        clr(1);
        tick_n(2);
        snap_chk("R7 wraps to zero", 0, 12'h000);
        tick_n(2);
        chk("R8 hit across wrap", 64'(irq), 64'b010);
        clr(1);
        wr(4'd6, 12'd0);
        tick_n(12'hFE0 - 3);
        chk("R7 passed target silent", 64'(irq), 64'd0);
        tick_n(1);
        chk("R7 fires after wrap", 64'(irq), 64'b001);
        clr(0);
        tick_n(4096);
        chk("R6 one-shot disarmed", 64'(irq), 64'd0);
    endtask

    initial begin
        rst = 1'b1; tick = 1'b0; halt_in = 1'b0; host_we = 1'b0;
        host_addr = '0; host_wdata = '0; irq_clr = '0;
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = '0; m_ld[c] = '0; m_pend[c] = 1'b0;
            m_run[c] = 1'b0; m_hs[c] = 1'b0;
        end
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_count();
        t_stall();
        t_load();
        t_target();
        t_sticky();
        t_select();
        t_disabled();
        t_period();
        t_wrap();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule